// File: doc/BRIEF.md
# Two-Wire Register-Space Slave with Persistent Pointer

This block is the serial front end of a 64-byte space that holds timekeeping registers and general RAM. It watches a two-wire bus (clock and data, both synchronized into the system clock), recognizes START, repeated START and STOP, and answers only to one fixed 7-bit device address. In a write transaction the first byte after the address sets an internal word pointer, and each later byte is stored at the pointer, which then advances. In a read transaction bytes are fetched from the pointer and shifted out MSB first, and the pointer steps on every acknowledge clock the master gives.

The pointer is kept across transactions. A master can therefore read from where the last access stopped without sending a word address first, or it can set the pointer and switch to reading with a repeated START. A separate output tells the timekeeping core to freeze its user-visible time copy while an access is pointing into the clock registers. The data line is open-drain: the block only ever pulls it low or releases it.

The register space itself sits outside the block and is reached through a byte-wide port. Its address is the pointer itself, a one-cycle write strobe carries the data, and the read data is combinational.

Top module: `i2c_regspace_slave`

## Requirements
- R1: After reset the data line is released, the write strobe and the clock-hold flag are low and the pointer is 00h.
- R2: An address byte whose upper seven bits are 1101000b is acknowledged (driven low in the ninth clock). Bit 0 of that byte selects write (0, byte D0h) or read (1, byte D1h).
- R3: An address byte with any other upper seven bits is not acknowledged. The block then drives nothing, writes nothing and leaves the pointer alone until the next START.
- R4: In a write transaction the first byte after the address is acknowledged and its low six bits are loaded into the pointer.
- R5: Each following write byte is acknowledged and strobed out once at the pointer address. The pointer advances by one at the end of that acknowledge clock.
- R6: In a read transaction bytes come from the pointer address, MSB first. The pointer advances by one on each master acknowledge (data low in the ninth clock).
- R7: A master not-acknowledge (data high in the ninth clock) leaves the pointer unchanged, and the block keeps the data line released until the next START or STOP.
- R8: A read that starts without a word-address write returns the byte at the pointer value left by the previous transaction, including across a STOP.
- R9: The pointer wraps from 3Fh to 00h, both when reading and when writing.
- R10: The clock-hold flag is high while an addressed access is in progress and the pointer is below 08h. It falls on STOP, and it falls as soon as the pointer reaches 08h or above.
- R11: A START or STOP that arrives part-way through a byte abandons that byte: nothing is written and the pointer does not move.
- R12: The block changes its drive of the data line only while the clock line is low.
- R13: A repeated START after a word-address write begins a new address phase, so a read can follow at the freshly loaded pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | When high, the pad pulls the data line low |
| reg_addr_o | output | ADDR_W | Register-space address (the pointer) |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data at reg_addr_o |
| clk_hold_o | output | 1 | Freeze request to the timekeeping core |

## Verification
Two functions can land on the same edge. The first pair is the step of the pointer at the end of a write acknowledge and the clock-hold decision, which must drop in the very cycle the pointer leaves 07h. The bench provokes this by writing a burst across 06h and 07h and then checking both the stored bytes and the flag, and it also checks that a hold set by a word-address write falls on STOP. The second pair is a START or STOP and an unfinished byte. The bench cuts a byte short with each kind of condition and then checks at the ports that memory and pointer are unchanged and that the following address phase still works.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } rs_state_e;

    typedef struct packed {
        rs_state_e           state;
        logic [3:0]          bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic                rw;
        logic                drive_low;
        logic                wr_en;
        logic                racked;
    } fsm_regs_t;

endpackage

// File: rtl/i2c_rs_linesync.sv
module i2c_rs_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_regs_t;

    sync_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        regs_d.scl_pipe[0] = scl_raw;
        regs_d.sda_pipe[0] = sda_raw;
        for (int i = 1; i < STAGES; i++) begin
            regs_d.scl_pipe[i] = regs_q.scl_pipe[i-1];
            regs_d.sda_pipe[i] = regs_q.sda_pipe[i-1];
        end
        regs_d.scl_prev = regs_q.scl_pipe[STAGES-1];
        regs_d.sda_prev = regs_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign scl_s    = regs_q.scl_pipe[STAGES-1];
    assign sda_s    = regs_q.sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~regs_q.scl_prev;
    assign scl_fall = ~scl_s & regs_q.scl_prev;
    assign start_ev = scl_s & regs_q.scl_prev & ~sda_s & regs_q.sda_prev;
    assign stop_ev  = scl_s & regs_q.scl_prev & sda_s & ~regs_q.sda_prev;

endmodule

// File: rtl/i2c_rs_pointer.sv
module i2c_rs_pointer #(
    parameter int ADDR_W     = 6,
    parameter int HOLD_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    input  logic              xfer_begin,
    input  logic              xfer_end,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              hold_o
);

    localparam logic [ADDR_W:0]   LIMIT_W = (ADDR_W+1)'(HOLD_LIMIT);
    localparam logic [ADDR_W-1:0] PTR_MAX = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              busy;
    } ptr_regs_t;

    ptr_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (load) begin
            regs_d.ptr = load_val;
        end else if (inc) begin
            regs_d.ptr = regs_q.ptr + 1'b1;
        end
        if (xfer_end) begin
            regs_d.busy = 1'b0;
        end else if (xfer_begin) begin
            regs_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ptr_o  = regs_q.ptr;
    assign hold_o = regs_q.busy && ({1'b0, regs_q.ptr} < LIMIT_W);

    // R9: stepping past the top address lands on zero
    a_r9_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc) && !$past(load) && ($past(regs_q.ptr) == PTR_MAX)) |-> (regs_q.ptr == '0));

    // R6: outside a load the pointer only ever moves by one
    a_r6_ptr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.ptr != $past(regs_q.ptr)) && !$past(load))
            |-> (regs_q.ptr == ADDR_W'($past(regs_q.ptr) + 1'b1)));

    // R10: a finished access never leaves the freeze request up
    a_r10_hold_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_end) |-> !hold_o);

endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [BYTE_W-1:0] rdata,
    output logic              drive_low,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] ptr_load_val,
    output logic              ptr_inc,
    output logic              xfer_begin,
    output logic              xfer_end
);

    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.wr_en = 1'b0;
        ptr_load     = 1'b0;
        ptr_load_val = ADDR_W'(regs_q.shreg);
        ptr_inc      = 1'b0;
        xfer_begin   = 1'b0;
        xfer_end     = 1'b0;

        if (stop_ev) begin
            regs_d.state     = ST_IDLE;
            regs_d.drive_low = 1'b0;
            xfer_end         = 1'b1;
        end else if (start_ev) begin
            regs_d.state     = ST_DEV;
            regs_d.bitcnt    = '0;
            regs_d.drive_low = 1'b0;
        end else begin
            unique case (regs_q.state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && regs_q.bitcnt < LAST_BIT) begin
                        regs_d.shreg  = {regs_q.shreg[BYTE_W-2:0], sda_s};
                        regs_d.bitcnt = regs_q.bitcnt + 1'b1;
                    end
                    if (scl_fall && regs_q.bitcnt == LAST_BIT) begin
                        if (regs_q.state == ST_DEV) begin
                            if (regs_q.shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                regs_d.rw        = regs_q.shreg[0];
                                regs_d.drive_low = 1'b1;
                                regs_d.state     = ST_DEV_ACK;
                                xfer_begin       = 1'b1;
                            end else begin
                                regs_d.state = ST_IGNORE;
                                xfer_end     = 1'b1;
                            end
                        end else if (regs_q.state == ST_WADDR) begin
                            ptr_load         = 1'b1;
                            regs_d.drive_low = 1'b1;
                            regs_d.state     = ST_WADDR_ACK;
                        end else begin
                            regs_d.wr_en     = 1'b1;
                            regs_d.drive_low = 1'b1;
                            regs_d.state     = ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        regs_d.bitcnt = '0;
                        if (regs_q.rw) begin
                            regs_d.shreg     = rdata;
                            regs_d.drive_low = ~rdata[BYTE_W-1];
                            regs_d.state     = ST_RDATA;
                        end else begin
                            regs_d.drive_low = 1'b0;
                            regs_d.state     = ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        regs_d.drive_low = 1'b0;
                        regs_d.bitcnt    = '0;
                        regs_d.state     = ST_WDATA;
                        ptr_inc          = (regs_q.state == ST_WDATA_ACK);
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        regs_d.bitcnt = regs_q.bitcnt + 1'b1;
                    end
                    if (scl_fall) begin
                        if (regs_q.bitcnt == LAST_BIT) begin
                            regs_d.drive_low = 1'b0;
                            regs_d.state     = ST_RACK;
                        end else begin
                            regs_d.shreg     = {regs_q.shreg[BYTE_W-2:0], 1'b0};
                            regs_d.drive_low = ~regs_q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        regs_d.racked = ~sda_s;
                        ptr_inc       = ~sda_s;
                    end
                    if (scl_fall) begin
                        if (regs_q.racked) begin
                            regs_d.shreg     = rdata;
                            regs_d.drive_low = ~rdata[BYTE_W-1];
                            regs_d.bitcnt    = '0;
                            regs_d.state     = ST_RDATA;
                        end else begin
                            regs_d.state = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.state <= ST_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign drive_low = regs_q.drive_low;
    assign wr_en     = regs_q.wr_en;
    assign wr_data   = regs_q.shreg;

    // R12: drive changes only follow a low clock line, or a bus condition
    a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.drive_low != $past(regs_q.drive_low))
            |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev)));

    // R3, R7: a slave that has stepped aside keeps the line released
    a_r3_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_IGNORE) |-> !regs_q.drive_low);

    // R5: the store strobe lasts one cycle
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.wr_en |=> !regs_q.wr_en);

    // R5: a stored byte is always being acknowledged at that moment
    a_r5_store_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.wr_en |-> regs_q.drive_low);

endmodule

// File: rtl/i2c_regspace_slave.sv
module i2c_regspace_slave
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         ADDR_W      = 6,
    parameter int         HOLD_LIMIT  = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_wr_o,
    output logic [7:0]        reg_wdata_o,
    input  logic [7:0]        reg_rdata_i,
    output logic              clk_hold_o
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              ptr_load, ptr_inc, xfer_begin, xfer_end;
    logic [ADDR_W-1:0] ptr_load_val;

    i2c_rs_linesync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_rs_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .ADDR_W   (ADDR_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_s        (scl_s),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_ev     (start_ev),
        .stop_ev      (stop_ev),
        .rdata        (reg_rdata_i),
        .drive_low    (sda_pull_o),
        .wr_en        (reg_wr_o),
        .wr_data      (reg_wdata_o),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_inc      (ptr_inc),
        .xfer_begin   (xfer_begin),
        .xfer_end     (xfer_end)
    );

    i2c_rs_pointer #(
        .ADDR_W     (ADDR_W),
        .HOLD_LIMIT (HOLD_LIMIT)
    ) ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ptr_load),
        .load_val   (ptr_load_val),
        .inc        (ptr_inc),
        .xfer_begin (xfer_begin),
        .xfer_end   (xfer_end),
        .ptr_o      (reg_addr_o),
        .hold_o     (clk_hold_o)
    );

endmodule

// File: tb/i2c_regspace_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_regspace_slave_tb_top;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic [5:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       clk_hold;
    logic       sda_line;

    logic [7:0] mem [64];
    logic [7:0] exp_mem [64];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int viol = 0;
    logic pull_prev = 1'b0;

    always #2 clk = ~clk;

    assign sda_line  = sda_m & ~sda_pull;
    assign reg_rdata = mem[reg_addr];

    i2c_regspace_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .reg_addr_o  (reg_addr),
        .reg_wr_o    (reg_wr),
        .reg_wdata_o (reg_wdata),
        .reg_rdata_i (reg_rdata),
        .clk_hold_o  (clk_hold)
    );

    // register space model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
        end
    end

    // R12 monitor: drive must not move while the bus clock is high
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_pull != pull_prev)) viol++;
        pull_prev <= sda_pull;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; wq(Q);
            scl_m = 1'b1;   wq(2*Q);
            scl_m = 1'b0;   wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = nack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 data line released", sda_pull, 0);
        chk("R1 hold low", clk_hold, 0);
        chk("R1 pointer zero", reg_addr, 0);
        chk("R1 no write strobe", reg_wr, 0);
    endtask

    task automatic t_write_burst();
        logic a;
        bus_start();
        send_byte(8'hD0, a); chk("R2 write address ack", a, 0);
        send_byte(8'h10, a); chk("R4 word address ack", a, 0);
        chk("R4 pointer loaded", reg_addr, 'h10);
        send_byte(8'hA5, a); chk("R5 data ack", a, 0);
        chk("R5 pointer advanced", reg_addr, 'h11);
        send_byte(8'h5A, a); chk("R5 second data ack", a, 0);
        bus_stop();
        exp_mem[8'h10] = 8'hA5; exp_mem[8'h11] = 8'h5A;
        chk("R5 stored first", mem[8'h10], exp_mem[8'h10]);
        chk("R5 stored second", mem[8'h11], exp_mem[8'h11]);
        chk("R5 pointer after burst", reg_addr, 'h12);
    endtask

    task automatic t_read_current();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD1, a); chk("R2 read address ack", a, 0);
        recv_byte(1'b0, b); chk("R8 read from kept pointer", b, exp_mem[8'h12]);
        chk("R6 pointer step on ack", reg_addr, 'h13);
        recv_byte(1'b1, b); chk("R6 next byte", b, exp_mem[8'h13]);
        chk("R7 no step on nack", reg_addr, 'h13);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        chk("R7 line released after nack", sda_line, 1);
        wq(Q); scl_m = 1'b0; wq(Q);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h3E, a);
        bus_start();
        send_byte(8'hD1, a); chk("R13 read after repeated start ack", a, 0);
        recv_byte(1'b0, b); chk("R13 byte at new pointer", b, exp_mem[8'h3E]);
        recv_byte(1'b0, b); chk("R9 top byte", b, exp_mem[8'h3F]);
        chk("R9 read wrap pointer", reg_addr, 0);
        recv_byte(1'b1, b); chk("R9 byte after wrap", b, exp_mem[0]);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h3F, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        bus_stop();
        exp_mem[8'h3F] = 8'h11; exp_mem[0] = 8'h22;
        chk("R9 write at top", mem[8'h3F], exp_mem[8'h3F]);
        chk("R9 write wrapped", mem[0], exp_mem[0]);
        chk("R9 write wrap pointer", reg_addr, 1);
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte(8'hA0, a); chk("R3 foreign address not acked", a, 1);
        send_byte(8'h00, a); chk("R3 later byte not acked", a, 1);
        send_byte(8'h55, a); chk("R3 data not acked", a, 1);
        bus_stop();
        chk("R3 pointer untouched", reg_addr, 1);
        chk("R3 memory untouched", mem[1], exp_mem[1]);
        bus_start();
        send_byte(8'hD2, a); chk("R3 near address not acked", a, 1);
        bus_stop();
    endtask

    task automatic t_hold();
        logic a;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h06, a);
        chk("R10 hold in clock range", clk_hold, 1);
        send_byte(8'h61, a);
        chk("R10 hold at 07h", clk_hold, 1);
        send_byte(8'h62, a);
        chk("R10 hold drops at 08h", clk_hold, 0);
        bus_stop();
        exp_mem[6] = 8'h61; exp_mem[7] = 8'h62;
        chk("R10 stored at 06h", mem[6], exp_mem[6]);
        chk("R10 stored at 07h", mem[7], exp_mem[7]);
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h03, a);
        chk("R10 hold before stop", clk_hold, 1);
        bus_stop();
        chk("R10 hold drops on stop", clk_hold, 0);
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h20, a);
        send_bits(8'h77, 4);
        bus_stop();
        chk("R11 stop mid byte no store", mem[8'h20], exp_mem[8'h20]);
        chk("R11 stop mid byte pointer", reg_addr, 'h20);
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h21, a);
        send_bits(8'h00, 3);
        bus_start();
        send_byte(8'hD1, a); chk("R11 address after mid-byte start", a, 0);
        recv_byte(1'b1, b); chk("R11 start mid byte no store", b, exp_mem[8'h21]);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'(i * 7 + 3);
        wq(10);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_write_burst();
        t_read_current();
        t_wrap();
        t_mismatch();
        t_hold();
        t_abort();
        chk("R12 drive changes only with clock low", viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule